// File: doc/BRIEF.md
# Predicated Vector Floating-Point Divider

This unit divides the elements of one 128-bit vector by the matching elements of a second vector. The element format is chosen for each operation: 16-bit half, 32-bit single or 64-bit double precision. A predicate with one bit per byte selects the lanes that take part. Lanes that take no part keep the first operand's bits unchanged, so the output is the first operand with the active lanes overwritten by their quotients.

One iterative restoring mantissa divider is shared by all lanes. It produces one quotient bit per cycle, plus a guard bit and a sticky bit. Lanes are visited from lowest to highest. An inactive lane takes one scan cycle and no divide cycles. A lane whose result is fixed by its operand classes (zero, infinity, NaN) is written in its scan cycle without using the divider. Rounding is round-to-nearest, ties-to-even. Subnormal inputs and results are flushed to zero. No flags are produced.

A caller drives the operands, the predicate and the size, then pulses `start` while the unit is idle. `busy` stays high while the operation runs. A one-cycle `done` pulse marks the cycle in which `res` first holds the finished vector.

Top module: `vfdiv_top`

## Requirements
- R1: `size` selects the element format: 2'b00 gives 16-bit half (8 lanes), 2'b01 gives 32-bit single (4 lanes), and 2'b10 or 2'b11 give 64-bit double (2 lanes). Lane k occupies bits [k*W+W-1 : k*W] of every vector, where W is the element width.
- R2: Lane k is active exactly when `pred` bit k*(W/8) is set, i.e. the bit for the lane's lowest byte. All other predicate bits have no effect.
- R3: Every inactive lane of `res` equals the matching lane of `opa` bit for bit. With no active lane, `res` equals `opa`.
- R4: For finite normal operands, an active lane holds the quotient opa/opb, rounded to nearest with ties to even.
- R5: A finite nonzero value divided by zero, and infinity divided by a finite value, give infinity. Zero divided by a nonzero value, and a finite value divided by infinity, give zero. In every one of these cases the result's sign is the XOR of the operand signs.
- R6: Zero divided by zero, infinity divided by infinity, and any NaN operand give the default quiet NaN: sign 0, exponent all ones, only the top fraction bit set (0x7E00, 0x7FC00000, 0x7FF8000000000000).
- R7: A quotient whose magnitude exceeds the largest finite value becomes a signed infinity. A quotient below the smallest normal value becomes a signed zero. A subnormal input is treated as a zero of the same sign.
- R8: `start` is accepted only while `busy` is low, and `busy` is high in the cycle after it is accepted. A `start` while busy has no effect on the running operation or on its result.
- R9: `done` is high for exactly one cycle, with `busy` low, and `res` then holds the result. `res` stays unchanged until the next accepted `start`.
- R10: Inactive lanes take no divide cycles. An operation with no active lane raises `done` within (lanes + 2) cycles of the `start` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| size | input | 2 | Element format select |
| pred | input | 16 | Predicate, one bit per byte of the vector |
| opa | input | 128 | Dividend vector, also the merge source |
| opb | input | 128 | Divisor vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res | output | 128 | Updated dividend vector |

## Verification
A fully active half-precision vector mixes exact quotients and inexact ones (one third, two thirds) with zero, infinity and NaN operands in neighbouring lanes. This separates the shared rounding path from the class shortcut path, and shows whether a lane write spills into its neighbours. Predicates with only odd-byte bits set, or with only a non-lowest byte of a lane set, distinguish lane-start decoding from any-bit decoding. Single-precision vectors that overflow, underflow and carry subnormal operands test the exponent limits and the flushing. Double-precision quotients are compared against the simulator's own correctly rounded real division. A second `start` during a busy operation, and an all-inactive predicate, check the handshake and the scan cost of skipped lanes.

// File: rtl/vfdiv_pkg.sv
package vfdiv_pkg;

  localparam int MANT_W = 53;          // hidden bit plus widest fraction
  localparam int EXP_W  = 14;          // signed unbiased exponent width
  localparam int CNT_W  = 6;           // divider iteration counter width

  typedef enum logic [1:0] {K_NUM, K_ZERO, K_INF, K_NAN} kind_e;

  typedef struct packed {
    logic                     sgn;
    logic signed [EXP_W-1:0]  exp;     // unbiased
    logic [MANT_W-1:0]        man;     // left aligned, hidden bit on top
    logic                     zero;
    logic                     inf;
    logic                     nan;
  } unp_t;

  function automatic logic [5:0] frac_bits(input logic [1:0] sz);
    case (sz)
      2'b00:   return 6'd10;
      2'b01:   return 6'd23;
      default: return 6'd52;
    endcase
  endfunction

  function automatic logic [10:0] bias_of(input logic [1:0] sz);
    case (sz)
      2'b00:   return 11'd15;
      2'b01:   return 11'd127;
      default: return 11'd1023;
    endcase
  endfunction

  function automatic logic [10:0] emax_of(input logic [1:0] sz);
    case (sz)
      2'b00:   return 11'd31;
      2'b01:   return 11'd255;
      default: return 11'd2047;
    endcase
  endfunction

  // log2 of the element size in bytes
  function automatic logic [1:0] byte_lg(input logic [1:0] sz);
    case (sz)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Assemble an element; frac is left aligned in 52 bits.
  function automatic logic [63:0] pack_elem(input logic [1:0] sz, input logic s,
                                            input kind_e k, input logic [10:0] e,
                                            input logic [51:0] frac);
    logic        so;
    logic [10:0] eo;
    logic [51:0] fo;
    logic [5:0]  fb;
    logic [6:0]  ew;
    so = s;
    eo = e;
    fo = frac;
    fb = frac_bits(sz);
    ew = 7'd8 << {5'd0, byte_lg(sz)};
    case (k)
      K_NAN:   begin so = 1'b0; eo = emax_of(sz); fo = {1'b1, 51'd0}; end
      K_INF:   begin eo = emax_of(sz); fo = '0; end
      K_ZERO:  begin eo = '0; fo = '0; end
      default: ;
    endcase
    return (64'(so) << (ew - 7'd1)) | (64'(eo) << fb) | 64'(fo >> (6'd52 - fb));
  endfunction

endpackage

// File: rtl/vfdiv_unpack.sv
module vfdiv_unpack
  import vfdiv_pkg::*;
(
  input  logic [1:0]  sz,
  input  logic [63:0] elem,
  output unp_t        u
);
  logic [10:0] raw_e;
  logic [51:0] raw_f;
  logic        sg;

  always_comb begin
    case (sz)
      2'b00:   begin sg = elem[15]; raw_e = {6'd0, elem[14:10]}; raw_f = {elem[9:0], 42'd0}; end
      2'b01:   begin sg = elem[31]; raw_e = {3'd0, elem[30:23]}; raw_f = {elem[22:0], 29'd0}; end
      default: begin sg = elem[63]; raw_e = elem[62:52];         raw_f = elem[51:0]; end
    endcase
    u.sgn  = sg;
    u.nan  = (raw_e == emax_of(sz)) && (raw_f != '0);
    u.inf  = (raw_e == emax_of(sz)) && (raw_f == '0);
    u.zero = (raw_e == '0);                          // subnormals flush to zero
    u.man  = {1'b1, raw_f};
    u.exp  = signed'(EXP_W'(raw_e)) - signed'(EXP_W'(bias_of(sz)));
  end
endmodule

// File: rtl/vfdiv_mdiv.sv
module vfdiv_mdiv #(
  parameter int MW = 53,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] iters,
  input  logic [MW-1:0] ma,
  input  logic [MW-1:0] mb,
  output logic [MW:0]   quo,
  output logic          rem_nz,
  output logic          fin
);
  localparam int RW = MW + 2;

  logic [RW-1:0] rem_q, rem_n;
  logic [MW:0]   quo_q, quo_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          fin_q, fin_n;
  logic          data_en;

  always_comb begin
    rem_n   = rem_q;
    quo_n   = quo_q;
    cnt_n   = cnt_q;
    fin_n   = 1'b0;
    data_en = 1'b0;
    if (load) begin
      data_en = 1'b1;
      rem_n   = (ma < mb) ? {1'b0, ma, 1'b0} : {2'b00, ma};
      quo_n   = '0;
      cnt_n   = iters;
    end else if (cnt_q != '0) begin
      data_en = 1'b1;
      if (rem_q >= {2'b00, mb}) begin
        quo_n = {quo_q[MW-1:0], 1'b1};
        rem_n = (rem_q - {2'b00, mb}) << 1;
      end else begin
        quo_n = {quo_q[MW-1:0], 1'b0};
        rem_n = rem_q << 1;
      end
      cnt_n = cnt_q - CW'(1);
      fin_n = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      fin_q <= fin_n;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
    end
  end

  assign quo    = quo_q;
  assign rem_nz = |rem_q;
  assign fin    = fin_q;
endmodule

// File: rtl/vfdiv_round.sv
module vfdiv_round
  import vfdiv_pkg::*;
(
  input  logic [1:0]              sz,
  input  kind_e                   kind_in,
  input  logic                    sgn,
  input  logic signed [EXP_W-1:0] exp_u,
  input  logic [MANT_W:0]         quo,
  input  logic                    sticky,
  output logic [63:0]             elem
);
  logic [MANT_W:0]          mr;
  logic                     inc, carry;
  logic [5:0]               fb;
  logic signed [EXP_W-1:0]  eb, emax_s;
  kind_e                    k;

  always_comb begin
    fb     = frac_bits(sz);
    inc    = quo[0] & (sticky | quo[1]);               // nearest, ties to even
    mr     = (quo >> 1) + (MANT_W+1)'(inc);
    carry  = |(mr >> (fb + 6'd1));
    emax_s = signed'(EXP_W'(emax_of(sz)));
    eb     = exp_u + signed'(EXP_W'(bias_of(sz))) + signed'(EXP_W'(carry));
    if (kind_in != K_NUM)  k = kind_in;
    else if (eb >= emax_s) k = K_INF;
    else if (eb <= 0)      k = K_ZERO;
    else                   k = K_NUM;
    elem = pack_elem(sz, sgn, k, 11'(eb), 52'(mr << (6'd52 - fb)));
  end
endmodule

// File: rtl/vfdiv_top.sv
module vfdiv_top
  import vfdiv_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         size,
  input  logic [VEC_W/8-1:0] pred,
  input  logic [VEC_W-1:0]   opa,
  input  logic [VEC_W-1:0]   opb,
  output logic               busy,
  output logic               done,
  output logic [VEC_W-1:0]   res
);
  localparam int PRED_W    = VEC_W / 8;
  localparam int MAX_LANES = VEC_W / 16;
  localparam int IDX_W     = $clog2(MAX_LANES) + 1;
  localparam int PIDX_W    = $clog2(PRED_W);
  localparam int SH_W      = $clog2(VEC_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DIV} st_e;

  // reset: asserted asynchronously, released on the clock
  logic rs_q1, rs_q2, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s = rs_q2;

  st_e                state_q, state_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic               done_q, done_n;
  logic [VEC_W-1:0]   acc_q, opb_q;
  logic [PRED_W-1:0]  pred_q;
  logic [1:0]         sz_q;
  logic               cap, wr, div_ld;

  logic [1:0]         lg, lg_in;
  logic [IDX_W-1:0]   lanes;
  logic [SH_W-1:0]    bsh;
  logic [PIDX_W-1:0]  pidx;
  logic [7:0]         ew;
  logic [VEC_W-1:0]   lane_mask, wr_vec, acc_n;
  logic [PRED_W-1:0]  lead;
  logic               any_act, lane_act, in_range;
  logic [63:0]        elem_a, elem_b, wr_elem;
  unp_t               ua, ub;
  kind_e              spec, kind_rd;
  logic [MANT_W:0]    quo;
  logic               rem_nz, div_fin;
  logic signed [EXP_W-1:0] exp_q;

  always_comb begin
    lg        = byte_lg(sz_q);
    lanes     = IDX_W'(MAX_LANES) >> (lg - 2'd1);
    in_range  = idx_q < lanes;
    bsh       = SH_W'(idx_q) << ({1'b0, lg} + 3'd3);
    pidx      = PIDX_W'(idx_q) << lg;
    lane_act  = pred_q[pidx];
    ew        = 8'd8 << lg;
    lane_mask = ((VEC_W'(1) << ew) - VEC_W'(1)) << bsh;
    elem_a    = 64'(acc_q >> bsh);
    elem_b    = 64'(opb_q >> bsh);
    lg_in     = byte_lg(size);
    for (int j = 0; j < PRED_W; j++)
      lead[j] = (PIDX_W'(j) & ((PIDX_W'(1) << lg_in) - PIDX_W'(1))) == '0;
    any_act   = |(pred & lead);
  end

  vfdiv_unpack u_ua (.sz(sz_q), .elem(elem_a), .u(ua));
  vfdiv_unpack u_ub (.sz(sz_q), .elem(elem_b), .u(ub));

  always_comb begin
    if (ua.nan || ub.nan || (ua.inf && ub.inf) || (ua.zero && ub.zero)) spec = K_NAN;
    else if (ua.inf || ub.zero)                                          spec = K_INF;
    else if (ua.zero || ub.inf)                                          spec = K_ZERO;
    else                                                                 spec = K_NUM;
    exp_q   = ua.exp - ub.exp - signed'(EXP_W'(ua.man < ub.man));
    kind_rd = (state_q == ST_DIV) ? K_NUM : spec;
  end

  vfdiv_mdiv #(.MW(MANT_W), .CW(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_s), .load(div_ld),
    .iters(frac_bits(sz_q) + 6'd2), .ma(ua.man), .mb(ub.man),
    .quo(quo), .rem_nz(rem_nz), .fin(div_fin)
  );

  vfdiv_round u_rnd (
    .sz(sz_q), .kind_in(kind_rd), .sgn(ua.sgn ^ ub.sgn), .exp_u(exp_q),
    .quo(quo), .sticky(rem_nz), .elem(wr_elem)
  );

  assign wr_vec = VEC_W'(wr_elem) << bsh;
  assign acc_n  = (acc_q & ~lane_mask) | (wr_vec & lane_mask);

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    done_n  = 1'b0;
    cap     = 1'b0;
    wr      = 1'b0;
    div_ld  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        cap     = 1'b1;
        idx_n   = '0;
        state_n = ST_SCAN;
      end
      ST_SCAN: begin
        if (!in_range) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else if (!lane_act) begin
          idx_n = idx_q + IDX_W'(1);
        end else if (spec != K_NUM) begin
          wr    = 1'b1;
          idx_n = idx_q + IDX_W'(1);
        end else begin
          div_ld  = 1'b1;
          state_n = ST_DIV;
        end
      end
      ST_DIV: if (div_fin) begin
        wr      = 1'b1;
        idx_n   = idx_q + IDX_W'(1);
        state_n = ST_SCAN;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      sz_q   <= size;
      pred_q <= pred;
      opb_q  <= any_act ? opb : '0;
    end
    if (cap)     acc_q <= opa;
    else if (wr) acc_q <= acc_n;
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign res  = acc_q;
endmodule

// File: rtl/vfdiv_chk.sv
module vfdiv_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [VEC_W-1:0] res
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(res));
endmodule

bind vfdiv_top vfdiv_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .start(start), .busy(busy), .done(done), .res(res)
);

// File: tb/sim_vfdiv_top.sv
module sim_vfdiv_top;
  logic         clk;
  logic         rst_n;
  logic         start;
  logic [1:0]   size;
  logic [15:0]  pred;
  logic [127:0] opa, opb;
  logic         busy, done;
  logic [127:0] res;

  int total = 0;
  int bad   = 0;

  vfdiv_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size), .pred(pred),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .res(res)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sz, input logic [15:0] pr,
                        input logic [127:0] a, input logic [127:0] b,
                        output logic [127:0] r, output int cyc);
    @(negedge clk);
    size = sz; pred = pr; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", {127'd0, busy}, 128'd1);
    cyc = 1;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    r = res;
    chk("R9 done seen", {127'd0, done}, 128'd1);
    chk("R9 busy low at done", {127'd0, busy}, 128'd0);
    @(negedge clk);
    chk("R9 done single cycle", {127'd0, done}, 128'd0);
    chk("R9 result held", res, r);
  endtask

  task automatic t_half_mix();
    logic [127:0] r; int c;
    run_op(2'b00, 16'hFFFF,
           128'h7C00_0000_BC00_3C00_C600_4000_3C00_4600,
           128'h7C00_0000_0000_0000_4200_4200_4200_4200, r, c);
    // R1 R4 R5 R6: lanes 0..3 quotients, 4..5 signed inf, 6..7 default NaN
    chk("R4 R5 R6 R1 half full vector", r,
        128'h7E00_7E00_FC00_7C00_C000_3955_3555_4000);
  endtask

  task automatic t_half_pred();
    logic [127:0] r; int c;
    // R2: odd-byte bits only -> no lane active
    run_op(2'b00, 16'hAAAA,
           128'h7C00_0000_BC00_3C00_C600_4000_3C00_4600,
           128'h7C00_0000_0000_0000_4200_4200_4200_4200, r, c);
    chk("R2 R3 odd predicate bits ignored", r,
        128'h7C00_0000_BC00_3C00_C600_4000_3C00_4600);
    // R2: lanes 0 and 1 only
    run_op(2'b00, 16'h0005,
           128'h7C00_0000_BC00_3C00_C600_4000_3C00_4600,
           128'h7C00_0000_0000_0000_4200_4200_4200_4200, r, c);
    chk("R2 R3 partial half merge", r,
        128'h7C00_0000_BC00_3C00_C600_4000_3555_4000);
  endtask

  task automatic t_single_limits();
    logic [127:0] r; int c;
    run_op(2'b01, 16'hFFFF,
           128'hC0000000_00800000_7F000000_3F800000,
           128'h00000001_40000000_3F000000_40400000, r, c);
    // R4 lane0 1/3 rounds up; R7 overflow, underflow, subnormal divisor
    chk("R4 R7 R1 single limits", r,
        128'hFF800000_00000000_7F800000_3EAAAAAB);
  endtask

  task automatic t_single_pred();
    logic [127:0] r; int c;
    // lane2 has only its second byte bit set -> inactive (R2)
    run_op(2'b01, 16'h1201,
           128'h80000000_DEADBEEF_12345678_40C00000,
           128'h3F800000_00000000_00000000_40400000, r, c);
    chk("R2 R3 R5 single merge and signed zero", r,
        128'h80000000_DEADBEEF_12345678_40000000);
  endtask

  task automatic t_double_real();
    logic [127:0] r; int c;
    run_op(2'b10, 16'h0101,
           {$realtobits(10.0), $realtobits(1.0)},
           {$realtobits(7.0), $realtobits(3.0)}, r, c);
    chk("R4 R1 double rounded quotients", r,
        {$realtobits(10.0 / 7.0), $realtobits(1.0 / 3.0)});
    // size 2'b11 also double; lane0 inactive via bits 1..7 only
    run_op(2'b11, 16'h01FE,
           {$realtobits(-1.5), $realtobits(-1.5)},
           {$realtobits(0.25), $realtobits(0.25)}, r, c);
    chk("R1 R2 R3 double alt code merge", r,
        {$realtobits(-6.0), $realtobits(-1.5)});
  endtask

  task automatic t_double_special();
    logic [127:0] r; int c;
    run_op(2'b10, 16'hFFFF,
           128'hFFF0000000000000_7FF0000000000001,
           128'h4000000000000000_3FF0000000000000, r, c);
    chk("R5 R6 double inf and signalling NaN", r,
        128'hFFF0000000000000_7FF8000000000000);
    run_op(2'b10, 16'hFFFF,
           128'hFFF8000000000123_4008000000000000,
           128'h3FF0000000000000_7FF0000000000000, r, c);
    chk("R5 R6 double over inf and negative NaN", r,
        128'h7FF8000000000000_0000000000000000);
  endtask

  task automatic t_none_active();
    logic [127:0] r; int c;
    run_op(2'b00, 16'h0000,
           128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
           128'h0, r, c);
    chk("R3 no active lane equals opa", r,
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    chk("R10 skip cost within lanes plus two", {96'd0, 32'(c <= 10)}, 128'd1);
  endtask

  task automatic t_busy_start();
    logic [127:0] r;
    int cyc;
    @(negedge clk);
    size = 2'b01; pred = 16'hFFFF; start = 1'b1;
    opa = {4{32'h3F800000}}; opb = {4{32'h40400000}};
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    opa = {4{32'h41200000}}; opb = {4{32'h3F800000}}; size = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    r = res;
    chk("R8 start while busy ignored", r, {4{32'h3EAAAAAB}});
    @(negedge clk);
    chk("R8 idle after ignored start", {127'd0, busy}, 128'd0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; size = 2'b00; pred = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset busy low", {127'd0, busy}, 128'd0);
    chk("R9 reset done low", {127'd0, done}, 128'd0);
    t_half_mix();
    t_half_pred();
    t_single_limits();
    t_single_pred();
    t_double_real();
    t_double_special();
    t_none_active();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule